// File: doc/BRIEF.md
# Cascaded Clock-Enable Divider Tree

This block takes a single fast core clock and produces a family of divided clock-enable strobes. Every strobe is one core cycle wide and changes on the core clock edge, so logic in each slower domain can keep running on the core clock and simply qualify its registers with the matching strobe. The first stage divides the core clock down to a bus rate. A second stage counts bus strobes, not core cycles, to produce an external-bus rate, so the core-to-external ratio is the product of the two stage ratios. A graphics branch and a static-memory branch also count bus strobes, each with its own selectable ratio.

Each divider takes its ratio from a small select field. A new select value is picked up only when that divider reaches the end of its current period, so no period is ever cut short. A synchronous reset clears every counter and lines the branches up so that all of them emit their first strobe on the same core cycle.

The block also keeps three bridge clock-source flags that are loaded from a 32-bit configuration word. When a flag is set, the matching bus bridge runs from its own external clock. When it is clear, the bridge runs from the internal external-bus clock, synchronously.

Top module: `clk_en_tree`

## Requirements
- R1: `bus_en` pulses once every N core cycles, where N = `bus_sel` + 1 (2'b00 gives /1, 2'b01 /2, 2'b10 /3, 2'b11 /4).
- R2: `ext_en` pulses on every M-th `bus_en` pulse, where M = `ext_sel` + 1. The core-to-external ratio is therefore N×M (for example `bus_sel`=2'b10 with `ext_sel`=3'b001 gives 6). `ext_en` is never high unless `bus_en` is high.
- R3: `gfx_en` pulses on every (`gfx_sel` + 1)-th `bus_en` pulse. With `gfx_sel`=2'b00 it equals `bus_en`.
- R4: `smc_en` pulses on every (`smc_sel` + 1)-th `bus_en` pulse. With `smc_sel`=2'b01 it pulses on every second bus strobe.
- R5: Each strobe is high for one core cycle per divided period and stays low for the rest of that period.
- R6: A change to a select input takes effect only after the current period of that divider ends. The period in progress keeps its old length.
- R7: While `rst` is high, all four strobes are low. On the first core cycle after `rst` falls, all four strobes are high together.
- R8: A cycle with `cfg_we` high loads `bridge_ext[0]`, `[1]` and `[2]` from `cfg_data` bits 22, 23 and 24 (bridges M1, M2 and S). Other data bits are ignored. With `cfg_we` low the flags hold.
- R9: `rst` clears all bridge flags to 0, which selects synchronous operation from the internal external-bus clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 2 | Bus divider select, ratio = value + 1 |
| ext_sel | input | 3 | External-bus divider select, ratio = value + 1, counted in bus strobes |
| gfx_sel | input | 2 | Graphics divider select, ratio = value + 1, counted in bus strobes |
| smc_sel | input | 2 | Static-memory divider select, ratio = value + 1, counted in bus strobes |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_data | input | 32 | Configuration word; bits 22..24 carry the bridge flags |
| bus_en | output | 1 | Bus clock-enable strobe |
| ext_en | output | 1 | External-bus clock-enable strobe |
| gfx_en | output | 1 | Graphics clock-enable strobe |
| smc_en | output | 1 | Static-memory clock-enable strobe |
| bridge_ext | output | 3 | Bridge external-clock selects: bit 0 M1, bit 1 M2, bit 2 S |

## Verification
Several properties are checked on every cycle. Each divider's spacing between strobes must equal the ratio that was latched when its period began, which also shows that a select change never shortens a period. Every derived strobe must coincide with a bus strobe. All strobes must rise together right after reset. The bridge flags must hold, load and clear as specified. The exact strobe patterns for each select combination, including the product ratio of the cascaded stages and the point at which a mid-period select change takes hold, can only be shown by the bench's scenarios. The same holds for ignoring the non-flag bits of the configuration word; the bench's cycle-by-cycle expected patterns cover all of these.

// File: rtl/clk_en_pkg.sv
package clk_en_pkg;

   // Strobe bundle of the tree, one bit per branch.
   typedef struct packed {
      logic bus;
      logic ext;
      logic gfx;
      logic smc;
   } en_vec_t;

   // Ratio encoded by a select value: value n divides by n+1.
   function automatic int unsigned ratio_of(input int unsigned sel);
      return sel + 1;
   endfunction

endpackage

// File: rtl/ce_div.sv
module ce_div #(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick_in,
   input  logic [SEL_W-1:0] sel,
   output logic             tick_out
);

   localparam int SPAN_W = SEL_W + 1;

   initial begin
      assert (SEL_W >= 1 && SEL_W <= 8)
         else $error("ce_div: SEL_W out of range");
   end

   logic [SEL_W-1:0] cnt_q;
   logic [SEL_W-1:0] lim_q;
   logic             term;

   assign term = (cnt_q == lim_q);

   // The period limit is taken from sel only at the terminal count.
   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         lim_q <= sel;
      end else if (tick_in) begin
         if (term) begin
            cnt_q <= '0;
            lim_q <= sel;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign tick_out = tick_in & (cnt_q == '0);

   // Period checker: input ticks between output strobes.
   logic [SPAN_W-1:0] since_q;
   logic [SEL_W-1:0]  prev_lim_q;
   logic              seen_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         since_q    <= '0;
         prev_lim_q <= '0;
         seen_q     <= 1'b0;
      end else if (tick_in) begin
         if (tick_out) begin
            since_q    <= SPAN_W'(1);
            prev_lim_q <= lim_q;
            seen_q     <= 1'b1;
         end else begin
            since_q <= since_q + 1'b1;
         end
      end
   end

   // R6 / R5: each period lasts exactly the ratio latched at its start.
   p_period_len_r6: assert property (@(posedge clk) disable iff (rst)
      (tick_out && seen_q) |-> (since_q == ({1'b0, prev_lim_q} + SPAN_W'(1))));

   // R5: counter never passes the active limit.
   p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= lim_q);

endmodule

// File: rtl/bridge_sel_reg.sv
module bridge_sel_reg #(
   parameter int CFG_W      = 32,
   parameter int BRIDGE_LSB = 22,
   parameter int N_BRIDGE   = 3
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                cfg_we,
   input  logic [CFG_W-1:0]    cfg_data,
   output logic [N_BRIDGE-1:0] bridge_ext
);

   initial begin
      assert (BRIDGE_LSB + N_BRIDGE <= CFG_W)
         else $error("bridge_sel_reg: flag field exceeds word");
   end

   always_ff @(posedge clk) begin
      if (rst)
         bridge_ext <= '0;
      else if (cfg_we)
         bridge_ext <= cfg_data[BRIDGE_LSB +: N_BRIDGE];
   end

   // R8: flags hold while no write occurs.
   p_flag_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !cfg_we |=> $stable(bridge_ext));

   // R8: a write captures exactly the flag field.
   p_flag_load_r8: assert property (@(posedge clk) disable iff (rst)
      cfg_we |=> (bridge_ext == $past(cfg_data[BRIDGE_LSB +: N_BRIDGE])));

   // R9: reset clears every flag.
   p_flag_clear_r9: assert property (@(posedge clk)
      rst |=> (bridge_ext == '0));

endmodule

// File: rtl/clk_en_tree.sv
module clk_en_tree #(
   parameter int BUS_SEL_W  = 2,
   parameter int EXT_SEL_W  = 3,
   parameter int PER_SEL_W  = 2,
   parameter int CFG_W      = 32,
   parameter int BRIDGE_LSB = 22,
   parameter int N_BRIDGE   = 3
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [BUS_SEL_W-1:0] bus_sel,
   input  logic [EXT_SEL_W-1:0] ext_sel,
   input  logic [PER_SEL_W-1:0] gfx_sel,
   input  logic [PER_SEL_W-1:0] smc_sel,
   input  logic                 cfg_we,
   input  logic [CFG_W-1:0]     cfg_data,
   output logic                 bus_en,
   output logic                 ext_en,
   output logic                 gfx_en,
   output logic                 smc_en,
   output logic [N_BRIDGE-1:0]  bridge_ext
);
   import clk_en_pkg::*;

   localparam int N_PER = 2;

   initial begin
      assert (N_BRIDGE >= 1) else $error("clk_en_tree: need a bridge flag");
   end

   logic core_tick;
   assign core_tick = ~rst;

   ce_div #(.SEL_W(BUS_SEL_W)) u_bus_div (
      .clk(clk), .rst(rst), .tick_in(core_tick), .sel(bus_sel), .tick_out(bus_en)
   );

   // Second stage counts bus strobes, so the ratios multiply.
   ce_div #(.SEL_W(EXT_SEL_W)) u_ext_div (
      .clk(clk), .rst(rst), .tick_in(bus_en), .sel(ext_sel), .tick_out(ext_en)
   );

   // Peripheral branches, all fed by the bus strobe.
   logic [PER_SEL_W-1:0] per_sel [N_PER];
   logic [N_PER-1:0]     per_en;

   assign per_sel[0] = gfx_sel;
   assign per_sel[1] = smc_sel;

   for (genvar g = 0; g < N_PER; g++) begin : g_per
      ce_div #(.SEL_W(PER_SEL_W)) u_per_div (
         .clk(clk), .rst(rst), .tick_in(bus_en), .sel(per_sel[g]),
         .tick_out(per_en[g])
      );
   end

   assign gfx_en = per_en[0];
   assign smc_en = per_en[1];

   bridge_sel_reg #(
      .CFG_W(CFG_W), .BRIDGE_LSB(BRIDGE_LSB), .N_BRIDGE(N_BRIDGE)
   ) u_bridge (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_data(cfg_data),
      .bridge_ext(bridge_ext)
   );

   en_vec_t en_now;
   assign en_now = '{bus: bus_en, ext: ext_en, gfx: gfx_en, smc: smc_en};

   // R7: all branches emit their first strobe together after reset.
   p_first_aligned_r7: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (en_now == 4'b1111));

   // R2 (and R3, R4): derived strobes only coincide with a bus strobe.
   p_nested_r2: assert property (@(posedge clk) disable iff (rst)
      (en_now.ext || en_now.gfx || en_now.smc) |-> en_now.bus);

endmodule

// File: tb/clk_en_tree_tb.sv
module clk_en_tree_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   typedef struct {
      logic [3:0] exp;
      string      tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [1:0]  bus_sel = '0;
   logic [2:0]  ext_sel = '0;
   logic [1:0]  gfx_sel = '0;
   logic [1:0]  smc_sel = '0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_data = '0;
   logic        bus_en, ext_en, gfx_en, smc_en;
   logic [2:0]  bridge_ext;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit done     = 1'b0;
   item_t sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   clk_en_tree dut_i (
      .clk(clk), .rst(rst), .bus_sel(bus_sel), .ext_sel(ext_sel),
      .gfx_sel(gfx_sel), .smc_sel(smc_sel), .cfg_we(cfg_we),
      .cfg_data(cfg_data), .bus_en(bus_en), .ext_en(ext_en),
      .gfx_en(gfx_en), .smc_en(smc_en), .bridge_ext(bridge_ext)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic finish_up();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   // Monitor: pops one expected strobe vector per cycle.
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         check({it.tag, " strobes {bus,ext,gfx,smc}"},
               {28'd0, bus_en, ext_en, gfx_en, smc_en}, {28'd0, it.exp});
      end
   end

   // Watchdog.
   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG && !done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got %0d cycles expected < %0d", cycles, WATCHDOG);
         finish_up();
      end
   end

   // Driver: applies one select setting and pushes the expected strobes.
   task automatic run_case(input int bs, input int es, input int gs, input int ss,
                           input int n, input int chg_k, input int new_bs,
                           input string tag);
      int b, bn, e, g, s, m, idx;
      logic vb;
      rst = 1'b1;
      bus_sel = 2'(bs); ext_sel = 3'(es); gfx_sel = 2'(gs); smc_sel = 2'(ss);
      repeat (3) @(posedge clk);
      #1;
      check("R7 strobes low in reset", {28'd0, bus_en, ext_en, gfx_en, smc_en}, 32'd0);
      b = bs + 1; bn = new_bs + 1; e = es + 1; g = gs + 1; s = ss + 1;
      m = (chg_k >= 0) ? ((chg_k / b) + 1) * b : 0;
      idx = 0;
      rst = 1'b0;
      for (int k = 0; k < n; k++) begin
         item_t it;
         if (k == chg_k) bus_sel = 2'(new_bs);
         if (chg_k >= 0 && k >= m) vb = ((k - m) % bn) == 0;
         else                      vb = (k % b) == 0;
         it.exp = {vb, vb && (idx % e == 0), vb && (idx % g == 0), vb && (idx % s == 0)};
         it.tag = (k == 0) ? "R7 first aligned" : tag;
         if (vb) idx++;
         sb_q.push_back(it);
         @(posedge clk);
         #1;
      end
      wait (sb_q.size() == 0);
   endtask

   initial begin
      // R9: flags clear out of reset.
      repeat (2) @(posedge clk);
      #1;
      check("R9 bridge flags after reset", {29'd0, bridge_ext}, 32'd0);

      // R1 R2 R3 R4 R5: divide-by-3 bus, divide-by-2 external (total 6).
      run_case(2, 1, 0, 1, 36, -1, 0, "R1 R2 R3 R4 R5 b3e2");
      // All divide-by-1.
      run_case(0, 0, 0, 0, 10, -1, 0, "R1 R2 R3 R4 R5 all1");
      // Largest ratios: bus 4, ext 8 (total 32), gfx 16, smc 12.
      run_case(3, 7, 3, 2, 70, -1, 0, "R1 R2 R3 R4 R5 max");
      // Mixed: bus 2, ext 3, gfx 4, smc 8.
      run_case(1, 2, 1, 3, 40, -1, 0, "R1 R2 R3 R4 R5 mix");
      // R6: bus select changed mid-period from /4 to /1.
      run_case(3, 1, 0, 1, 20, 1, 0, "R6 late select");
      // R6: change exactly on a strobe cycle, /3 to /2.
      run_case(2, 0, 1, 0, 24, 3, 1, "R6 change on strobe");

      // R8: load from bits 22..24, all other bits set.
      @(posedge clk); #1;
      cfg_data = 32'hFF7F_FFFF; cfg_we = 1'b1;
      @(posedge clk); #1;
      cfg_we = 1'b0; cfg_data = 32'h0000_0000;
      check("R8 bridge load 22..24", {29'd0, bridge_ext}, 32'd5);
      repeat (3) @(posedge clk);
      #1;
      check("R8 bridge hold without write", {29'd0, bridge_ext}, 32'd5);
      cfg_data = 32'h0180_0000; cfg_we = 1'b1;
      @(posedge clk); #1;
      cfg_we = 1'b0;
      check("R8 bridge second load", {29'd0, bridge_ext}, 32'd6);
      cfg_data = 32'hFE3F_FFFF; cfg_we = 1'b1;
      @(posedge clk); #1;
      cfg_we = 1'b0;
      check("R8 non-flag bits ignored", {29'd0, bridge_ext}, 32'd0);
      cfg_data = 32'h01C0_0000; cfg_we = 1'b1;
      @(posedge clk); #1;
      cfg_we = 1'b0;
      check("R8 all flags set", {29'd0, bridge_ext}, 32'd7);
      rst = 1'b1;
      @(posedge clk); #1;
      check("R9 reset clears flags", {29'd0, bridge_ext}, 32'd0);
      rst = 1'b0;
      @(posedge clk); #1;

      done = 1'b1;
      finish_up();
   end

endmodule